// File: doc/BRIEF.md
# Fetch-Decode-Execute Control Sequencer

This block sequences a small accumulator machine through the fetch, decode, address and execute slots of each instruction. A 3-bit timing slot steps from T0 upward. In each slot the controller raises load and increment enables for the program counter, memory address register, memory buffer register, instruction register and accumulator. It also raises the read and write strobes of a synchronous single-port memory. The memory returns read data one cycle after the strobe. A small ALU operand path computes load, add and and results, applies register operations and returns a branch condition to the controller.

The instruction word is 16 bits wide. Bit 15 selects indirect addressing, bits 14:12 hold the opcode and bits 11:0 hold the address. Opcode 7 is a register/IO instruction. Its address field is a set of operation bits, and the whole instruction finishes in T3. Memory instructions use T3 as their address slot: an indirect one reads its pointer there and a direct one idles. The output port is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the sequencer holds T3, and `out_data` and every register stay frozen. A word moves on a cycle where both are high.

Top module: `instr_cycle_seq`

## Requirements
- R1: In T0 the sequencer reads memory at the PC, loads the MAR with the PC and increments the PC, so `pc` shows the old value plus one from T1 on.
- R2: Read data is captured into the MBR one slot after the read. The MBR moves into the IR in T2, so `ir` shows the new word from T3.
- R3: Opcode 7 finishes in T3 after 4 slots. Its operation bits act in this order: bit 0 clears the AC, bit 2 complements it, and bit 1 increments it.
- R4: With bit 15 set, the word at IR[11:0] is read in T3 and its low 12 bits become the effective address. With bit 15 clear, T3 idles and IR[11:0] is the effective address. Both forms take the same number of slots, and a memory operand read in T5 uses the effective address.
- R5: Opcodes 0 (AND), 1 (ADD) and 2 (load) read the operand in T5 and update the AC in T7, for 8 slots in all. Opcode 3 (store) moves the AC into the MBR in T5 and writes it to the effective address in T6, for 7 slots.
- R6: Opcodes 4 (always), 5 (AC zero) and 6 (AC bit 15 set) are branches. The ALU returns the condition, and when it holds the PC takes the effective address in T5. A branch takes 6 slots.
- R7: Operation bit 10 of opcode 7 raises `out_valid` in T3. `out_data` carries the AC value from before this instruction's register operation. T3 and `out_data` are held until `out_ready` is high.
- R8: Operation bit 11 of opcode 7 sets `halted` once T3 completes, after any output transfer. From then on there is no memory access and `pc` is frozen until reset.
- R9: A synchronous reset returns the slot to T0 and clears `pc`, `ir`, the AC and `halted`.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address for the current strobe |
| mem_rd | output | 1 | Memory read strobe; data arrives next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Write data (MBR contents) |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| out_valid | output | 1 | Output stream word valid |
| out_ready | input | 1 | Output stream sink ready |
| out_data | output | 16 | Output stream word (AC) |
| halted | output | 1 | Sequencer stopped by a halt instruction |
| pc | output | 12 | Program counter |
| ir | output | 16 | Instruction register |
| tslot | output | 3 | Current timing slot (0 = T0) |

## Verification
Two functions can fall in one T3 cycle: the output handshake and the register operation that rewrites the AC. The output must carry the value from before the update. The test program pairs output with complement and with increment, and `out_ready` is held low for two of every three cycles, so T3 stalls before it completes. A behavioural instruction interpreter in the bench predicts the slot, PC, IR, strobes and stream word on every clock. The bench compares each one, including the held word during stall cycles and the transferred value.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int WORD_W = 16;
  localparam int ADR_W  = 12;
  localparam int OPC_W  = 3;

  typedef enum logic [2:0] {T0, T1, T2, T3, T4, T5, T6, T7} slot_t;
  typedef enum logic [1:0] {ADR_PC, ADR_IR, ADR_MAR} addr_sel_t;
  typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IR, MAR_RDATA} mar_sel_t;
  typedef enum logic [1:0] {MBR_HOLD, MBR_RDATA, MBR_AC} mbr_sel_t;
  typedef enum logic [1:0] {AC_HOLD, AC_ALU, AC_REG} ac_sel_t;

  localparam logic [OPC_W-1:0] OP_AND = 3'd0;
  localparam logic [OPC_W-1:0] OP_ADD = 3'd1;
  localparam logic [OPC_W-1:0] OP_LDA = 3'd2;
  localparam logic [OPC_W-1:0] OP_STA = 3'd3;
  localparam logic [OPC_W-1:0] OP_JMP = 3'd4;
  localparam logic [OPC_W-1:0] OP_JZ  = 3'd5;
  localparam logic [OPC_W-1:0] OP_JN  = 3'd6;
  localparam logic [OPC_W-1:0] OP_REG = 3'd7;

  localparam int RB_CLR = 0;
  localparam int RB_INC = 1;
  localparam int RB_CPL = 2;
  localparam int RB_OUT = 10;
  localparam int RB_HLT = 11;

  typedef struct packed {
    logic      pc_inc;
    logic      pc_load;
    mar_sel_t  mar_sel;
    mbr_sel_t  mbr_sel;
    logic      ir_load;
    ac_sel_t   ac_sel;
    logic      mem_rd;
    logic      mem_wr;
    addr_sel_t addr_sel;
    logic      out_valid;
  } ctl_t;
endpackage

// File: rtl/ics_alu.sv
module ics_alu
  import ics_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [2:0]       rbits,
  input  logic [DW-1:0]    ac,
  input  logic [DW-1:0]    mbr,
  output logic [DW-1:0]    mem_res,
  output logic [DW-1:0]    reg_res,
  output logic             cond
);
  logic [DW-1:0] v_clr, v_cpl;

  always_comb begin
    unique case (opc)
      OP_AND:  mem_res = ac & mbr;
      OP_ADD:  mem_res = ac + mbr;
      OP_LDA:  mem_res = mbr;
      default: mem_res = ac;
    endcase
  end

  always_comb begin
    v_clr   = rbits[RB_CLR] ? '0 : ac;
    v_cpl   = rbits[RB_CPL] ? ~v_clr : v_clr;
    reg_res = rbits[RB_INC] ? v_cpl + 1'b1 : v_cpl;
  end

  always_comb begin
    unique case (opc)
      OP_JMP:  cond = 1'b1;
      OP_JZ:   cond = (ac == '0);
      OP_JN:   cond = ac[DW-1];
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/ics_ctrl.sv
module ics_ctrl
  import ics_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ind,
  input  logic [OPC_W-1:0] opc,
  input  logic             r_out,
  input  logic             r_hlt,
  input  logic             alu_cond,
  input  logic             out_ready,
  output ctl_t             ctl,
  output slot_t            slot,
  output logic             halted
);
  slot_t slot_q, slot_d;
  logic  halt_q, halt_d;
  logic  is_reg, is_jmp, is_sta;

  assign is_reg = (opc == OP_REG);
  assign is_jmp = (opc == OP_JMP) || (opc == OP_JZ) || (opc == OP_JN);
  assign is_sta = (opc == OP_STA);

  always_comb begin
    ctl    = '0;
    slot_d = slot_q;
    halt_d = halt_q;
    if (!halt_q) begin
      unique case (slot_q)
        T0: begin
          ctl.mar_sel  = MAR_PC;
          ctl.mem_rd   = 1'b1;
          ctl.addr_sel = ADR_PC;
          ctl.pc_inc   = 1'b1;
          slot_d       = T1;
        end
        T1: begin
          ctl.mbr_sel = MBR_RDATA;
          slot_d      = T2;
        end
        T2: begin
          ctl.ir_load = 1'b1;
          slot_d      = T3;
        end
        T3: begin
          if (is_reg) begin
            ctl.out_valid = r_out;
            if (!r_out || out_ready) begin
              ctl.ac_sel = AC_REG;
              halt_d     = r_hlt;
              slot_d     = T0;
            end
          end else begin
            if (ind) begin
              ctl.mem_rd   = 1'b1;
              ctl.addr_sel = ADR_IR;
              ctl.mar_sel  = MAR_IR;
            end
            slot_d = T4;
          end
        end
        T4: begin
          ctl.mar_sel = ind ? MAR_RDATA : MAR_IR;
          if (ind) ctl.mbr_sel = MBR_RDATA;
          slot_d = T5;
        end
        T5: begin
          if (is_jmp) begin
            ctl.pc_load = alu_cond;
            slot_d      = T0;
          end else if (is_sta) begin
            ctl.mbr_sel = MBR_AC;
            slot_d      = T6;
          end else begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_sel = ADR_MAR;
            slot_d       = T6;
          end
        end
        T6: begin
          if (is_sta) begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_sel = ADR_MAR;
            slot_d       = T0;
          end else begin
            ctl.mbr_sel = MBR_RDATA;
            slot_d      = T7;
          end
        end
        default: begin
          ctl.ac_sel = AC_ALU;
          slot_d     = T0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= T0;
      halt_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      halt_q <= halt_d;
    end
  end

  assign slot   = slot_q;
  assign halted = halt_q;

  AST_REG_DONE: assert property (@(posedge clk) disable iff (rst)
    (slot_q == T3 && is_reg && ctl.ac_sel == AC_REG) |=> slot_q == T0); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl.out_valid && !out_ready) |=> (ctl.out_valid && slot_q == T3)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && slot_q == T0 && !ctl.mem_rd && !ctl.mem_wr)); // R8
endmodule

// File: rtl/ics_datapath.sv
module ics_datapath
  import ics_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] mem_res,
  input  logic [DW-1:0] reg_res,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] ac,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] pc
);
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, ir_q, ac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
    end else begin
      if (ctl.pc_inc)       pc_q <= pc_q + 1'b1;
      else if (ctl.pc_load) pc_q <= mar_q;
      unique case (ctl.mar_sel)
        MAR_PC:    mar_q <= pc_q;
        MAR_IR:    mar_q <= ir_q[AW-1:0];
        MAR_RDATA: mar_q <= mem_rdata[AW-1:0];
        default:   mar_q <= mar_q;
      endcase
      unique case (ctl.mbr_sel)
        MBR_RDATA: mbr_q <= mem_rdata;
        MBR_AC:    mbr_q <= ac_q;
        default:   mbr_q <= mbr_q;
      endcase
      if (ctl.ir_load) ir_q <= mbr_q;
      unique case (ctl.ac_sel)
        AC_ALU:  ac_q <= mem_res;
        AC_REG:  ac_q <= reg_res;
        default: ac_q <= ac_q;
      endcase
    end
  end

  always_comb begin
    unique case (ctl.addr_sel)
      ADR_IR:  mem_addr = ir_q[AW-1:0];
      ADR_MAR: mem_addr = mar_q;
      default: mem_addr = pc_q;
    endcase
  end

  assign mbr = mbr_q;
  assign ac  = ac_q;
  assign ir  = ir_q;
  assign pc  = pc_q;

  AST_FETCH_INC: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_inc |=> (pc_q == $past(pc_q) + 1'b1 && mar_q == $past(pc_q))); // R1
  AST_IR_FROM_MBR: assert property (@(posedge clk) disable iff (rst)
    ctl.ir_load |=> ir_q == $past(mbr_q)); // R2
  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_wr |-> mbr_q == ac_q); // R5
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import ics_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADR_W
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          halted,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [2:0]    tslot
);
  localparam int IND_BIT = DW - 1;
  localparam int OPC_LSB = AW;

  ctl_t          ctl;
  slot_t         slot;
  logic [DW-1:0] mbr, ac, mem_res, reg_res;
  logic          cond;
  logic [OPC_W-1:0] opc;

  assign opc = ir[OPC_LSB +: OPC_W];

  ics_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ind(ir[IND_BIT]), .opc(opc),
    .r_out(ir[RB_OUT]), .r_hlt(ir[RB_HLT]), .alu_cond(cond),
    .out_ready(out_ready), .ctl(ctl), .slot(slot), .halted(halted)
  );

  ics_alu #(.DW(DW)) u_alu (
    .opc(opc), .rbits(ir[2:0]), .ac(ac), .mbr(mbr),
    .mem_res(mem_res), .reg_res(reg_res), .cond(cond)
  );

  ics_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
    .mem_res(mem_res), .reg_res(reg_res), .mem_addr(mem_addr),
    .mbr(mbr), .ac(ac), .ir(ir), .pc(pc)
  );

  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = mbr;
  assign out_valid = ctl.out_valid;
  assign out_data  = ac;
  assign tslot     = slot;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R10
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc)); // R8
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data)); // R7
endmodule

// File: tb/test_instr_cycle_seq.sv
module test_instr_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, out_valid, halted;
  logic        out_ready = 1'b0;
  logic [15:0] mem_wdata, out_data, ir;
  logic [15:0] mem_rdata = '0;
  logic [11:0] pc;
  logic [2:0]  tslot;

  always #2 clk = ~clk;

  instr_cycle_seq i_instr_cycle_seq (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .halted(halted), .pc(pc), .ir(ir), .tslot(tslot)
  );

  logic [15:0] mem   [256];
  logic [15:0] mem_m [256];
  int vectors = 0, errs = 0, cyc = 0, n_out = 0;
  bit armed = 0;

  // memory: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // behavioural instruction interpreter
  int          m_slot;
  int          m_pc, m_halt;
  logic [15:0] m_ir, m_ac, m_fetch;
  int          m_ea;

  function automatic logic [15:0] regop(logic [15:0] a, logic [15:0] w);
    logic [15:0] v = a;
    if (w[0]) v = 16'h0;
    if (w[2]) v = ~v;
    if (w[1]) v = v + 16'd1;
    return v;
  endfunction

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      m_slot = 0; m_pc = 0; m_halt = 0; m_ir = '0; m_ac = '0;
    end else if (m_halt == 0) begin
      case (m_slot)
        0: begin m_fetch = mem_m[m_pc[7:0]]; m_pc = (m_pc + 1) % 4096; m_slot = 1; end
        1: m_slot = 2;
        2: begin m_ir = m_fetch; m_slot = 3; end
        3: begin
          if (m_ir[14:12] == 3'd7) begin
            if (!m_ir[10] || out_ready) begin
              if (m_ir[10]) n_out++;
              m_ac = regop(m_ac, m_ir);
              if (m_ir[11]) m_halt = 1;
              m_slot = 0;
            end
          end else begin
            m_ea = m_ir[15] ? int'(mem_m[m_ir[7:0]][11:0]) : int'(m_ir[11:0]);
            m_slot = 4;
          end
        end
        4: m_slot = 5;
        5: begin
          case (m_ir[14:12])
            3'd4: begin m_pc = m_ea; m_slot = 0; end
            3'd5: begin if (m_ac == 0) m_pc = m_ea; m_slot = 0; end
            3'd6: begin if (m_ac[15]) m_pc = m_ea; m_slot = 0; end
            default: m_slot = 6;
          endcase
        end
        6: begin
          if (m_ir[14:12] == 3'd3) begin mem_m[m_ea[7:0]] = m_ac; m_slot = 0; end
          else m_slot = 7;
        end
        default: begin
          case (m_ir[14:12])
            3'd0: m_ac = m_ac & mem_m[m_ea[7:0]];
            3'd1: m_ac = m_ac + mem_m[m_ea[7:0]];
            default: m_ac = mem_m[m_ea[7:0]];
          endcase
          m_slot = 0;
        end
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge; drive ready afterwards
  always @(negedge clk) begin
    if (armed) begin
      bit exp_wr, exp_out, exp_opnd;
      exp_wr   = (m_halt == 0) && m_slot == 6 && m_ir[14:12] == 3'd3;
      exp_out  = (m_halt == 0) && m_slot == 3 && m_ir[14:12] == 3'd7 && m_ir[10];
      exp_opnd = (m_halt == 0) && m_slot == 5 && m_ir[14:12] <= 3'd2;
      chk("R3/R4/R5/R6", "tslot", int'(tslot), m_slot);
      chk("R1", "pc", int'(pc), m_pc);
      chk("R2", "ir", int'(ir), int'(m_ir));
      chk("R8", "halted", int'(halted), m_halt);
      chk("R5", "mem_wr", int'(mem_wr), int'(exp_wr));
      chk("R10", "rd&wr", int'(mem_rd & mem_wr), 0);
      chk("R7", "out_valid", int'(out_valid), int'(exp_out));
      if (exp_wr) begin
        chk("R5", "store addr", int'(mem_addr), m_ea);
        chk("R5", "store data", int'(mem_wdata), int'(m_ac));
      end
      if (exp_out) chk("R7", "out_data", int'(out_data), int'(m_ac));
      if (m_halt == 0 && m_slot == 0) begin
        chk("R1", "fetch rd", int'(mem_rd), 1);
        chk("R1", "fetch addr", int'(mem_addr), m_pc);
      end
      if (exp_opnd) begin
        chk("R4", "operand rd", int'(mem_rd), 1);
        chk("R4", "operand addr", int'(mem_addr), m_ea);
      end
      if (m_halt != 0) chk("R8", "no access", int'(mem_rd | mem_wr), 0);
    end
    cyc++;
    out_ready = (cyc % 3 == 2);
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[0]  = 16'h2040; mem[1]  = 16'h9041; mem[2]  = 16'h3050;
    mem[3]  = 16'h0043; mem[4]  = 16'h7404; mem[5]  = 16'h5008;
    mem[6]  = 16'h7001; mem[7]  = 16'h5009; mem[8]  = 16'h7800;
    mem[9]  = 16'h7402; mem[10] = 16'hE044; mem[11] = 16'h7004;
    mem[12] = 16'h600E; mem[13] = 16'h7800; mem[14] = 16'hB045;
    mem[15] = 16'h4011; mem[16] = 16'h7800; mem[17] = 16'h7400;
    mem[18] = 16'h7800;
    mem[8'h40] = 16'h1234; mem[8'h41] = 16'h0042; mem[8'h42] = 16'h0101;
    mem[8'h43] = 16'h0FF0; mem[8'h44] = 16'h000E; mem[8'h45] = 16'h0051;
    for (int i = 0; i < 256; i++) mem_m[i] = mem[i];

    repeat (3) @(negedge clk);
    #1;
    chk("R9", "reset tslot", int'(tslot), 0);
    chk("R9", "reset pc", int'(pc), 0);
    chk("R9", "reset ir", int'(ir), 0);
    chk("R9", "reset halted", int'(halted), 0);
    rst = 1'b0;

    while (!halted && cyc < 5000) @(negedge clk);
    if (cyc >= 5000) begin
      errs++; vectors++;
      $display("FAIL R8 watchdog: actual running expected halted");
    end
    repeat (20) @(negedge clk);
    #1;
    chk("R8", "final pc frozen", int'(pc), 19);
    chk("R5", "direct store", int'(mem[8'h50]), 16'h1335);
    chk("R4", "indirect store", int'(mem[8'h51]), 16'hFFFE);
    chk("R7", "outputs moved", n_out, 3);

    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    #1;
    chk("R9", "re-reset pc", int'(pc), 0);
    chk("R9", "re-reset halted", int'(halted), 0);
    chk("R9", "re-reset ir", int'(ir), 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule